// File: doc/BRIEF.md
# Block Buffer Data Port

This block is the programmed-I/O staging buffer of an SD host controller. It holds one data block between a register-mapped data port on the host side and a byte-wide card data interface. On the read path the command logic issues a fill request. The block takes one block of bytes from the card through a valid/ready handshake and raises its data-available flag. Software then drains the buffer through port reads of 1, 2 or 4 bytes, and the bytes come back packed little-endian.

On the write path a write request raises the space-available flag. Software fills the buffer through port writes of 1, 2 or 4 bytes. Once the last byte of the block is in, the block streams the buffer to the card one byte per accepted beat, in index order.

A tuning request switches the next fill to a discard mode. A full block is taken from the card but is not stored. At the end of it the tuning request bit clears, the sampling-clock-select bit sets, and a one-cycle completion pulse tells the command logic to release its line-busy, read-busy and inhibit status.

Top module: `sdbuf_port`

## Requirements
- R1: Buffer capacity is 512 << CAP_SEL bytes, and CAP_SEL = 3 stops elaboration. A block length larger than the capacity is treated as exactly the capacity.
- R2: The block length in bytes is the 12-bit `blk_len_i` (1 to 4095). A fill request or a write request that arrives while the length is zero is ignored.
- R3: A port read with size code 0, 1 or 2 (code 3 acts as 2) returns 1, 2 or 4 successive buffer bytes. Buffer byte k of the access is placed in bits [8k+7:8k], so the lowest index is least significant. Byte lanes that lie past the end of the block read as zero. The data appears on `port_rdata_o` in the cycle after the access.
- R4: When the read byte counter reaches the block length, data-available clears after that clock edge and the counter returns to 0, so the next fill is read from index 0.
- R5: A port write stores byte k from bits [8k+7:8k] at the next buffer index, and lanes past the end of the block are dropped. When the write byte counter reaches the block length, space-available clears and the block is sent to the card in index order.
- R6: A fill request is skipped, and no card byte is accepted, when `multi_blk_i`, `blk_cnt_en_i` and `blk_cnt_zero_i` are all set.
- R7: With the tuning bit set, a fill takes a full block from the card without storing it and without raising data-available. It then clears the tuning bit, sets `samp_clk_sel_o`, and pulses `tune_done_o` for one cycle.
- R8: A port read while data-available is clear returns zero. A port write while space-available is clear is dropped.
- R9: Reset, synchronous and active low, clears both counters, both flags, the tuning bit, the sampling-clock-select bit and the card handshake outputs.
- R10: On the card side, a byte moves only on a cycle where valid and ready are both high. While the card holds ready low during a drain, the outgoing byte is held stable.
- R11: Fill, write and tuning requests are ignored unless the block is idle, which means no flag is set and no card transfer is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blk_len_i | input | 12 | Block length in bytes |
| multi_blk_i | input | 1 | Multi-block transfer mode |
| blk_cnt_en_i | input | 1 | Block counting enabled |
| blk_cnt_zero_i | input | 1 | Remaining block count is zero |
| rd_start_i | input | 1 | Request a card-to-buffer fill |
| wr_start_i | input | 1 | Open the buffer for host writes |
| tune_start_i | input | 1 | Set the tuning request bit |
| port_rd_i | input | 1 | Host data-port read strobe |
| port_wr_i | input | 1 | Host data-port write strobe |
| port_size_i | input | 2 | Access size code: 0=1, 1=2, 2/3=4 bytes |
| port_wdata_i | input | 32 | Host write data |
| port_rdata_o | output | 32 | Host read data, registered |
| data_avail_o | output | 1 | Buffer holds a block for the host to read |
| space_avail_o | output | 1 | Buffer accepts host writes |
| card_rx_valid_i | input | 1 | Card byte valid |
| card_rx_data_i | input | 8 | Card byte |
| card_rx_ready_o | output | 1 | Block accepts a card byte |
| card_tx_valid_o | output | 1 | Outgoing byte valid |
| card_tx_data_o | output | 8 | Outgoing byte |
| card_tx_ready_i | input | 1 | Card accepts the outgoing byte |
| exec_tune_o | output | 1 | Tuning request bit |
| samp_clk_sel_o | output | 1 | Sampling clock select bit |
| tune_done_o | output | 1 | One-cycle pulse at the end of a tuning block |

## Verification
The bench goes after the block tail. It uses lengths that are not a multiple of the access size, because a design that counted whole accesses would leak stale bytes into the top lanes or would never clear its flag. It reads past the end of a block and writes to an unopened buffer, where a design that ignored the flags would return old data or corrupt the next block. It covers the skip condition, the discard during tuning and a length above capacity. It also stalls both handshakes, since a design that counted cycles instead of beats would shift every later byte by one index.

// File: rtl/sdbuf_pkg.sv
package sdbuf_pkg;
    // Transfer phase of the buffer
    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_FILL    = 3'd1,
        PH_HOST_RD = 3'd2,
        PH_HOST_WR = 3'd3,
        PH_DRAIN   = 3'd4
    } phase_t;

    // Bytes moved by one port access of the given size code
    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        case (code)
            2'd0:    size_bytes = 3'd1;
            2'd1:    size_bytes = 3'd2;
            default: size_bytes = 3'd4;
        endcase
    endfunction
endpackage

// File: rtl/sdbuf_mem.sv
// Byte-wide block buffer.
// Provides LANES host write lanes, LANES asynchronous host read lanes,
// one card write port and one card read port.
// Assumes host and card never write in the same cycle. The phase logic
// guarantees this, and if both did write, the card port would win.
module sdbuf_mem #(
    parameter int DEPTH = 512,
    parameter int AW    = 9,
    parameter int LANES = 4
) (
    input  logic                        clk,
    input  logic [LANES-1:0]            h_we_i,
    input  logic [LANES-1:0][AW-1:0]    h_addr_i,
    input  logic [LANES-1:0][7:0]       h_wdata_i,
    output logic [LANES-1:0][7:0]       h_rdata_o,
    input  logic                        c_we_i,
    input  logic [AW-1:0]               c_addr_i,
    input  logic [7:0]                  c_wdata_i,
    output logic [7:0]                  c_rdata_o
);
    logic [7:0] mem_q [DEPTH];

    // Byte writes from the host lanes, then the card port
    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (h_we_i[i]) mem_q[h_addr_i[i]] <= h_wdata_i[i];
        end
        if (c_we_i) mem_q[c_addr_i] <= c_wdata_i;
    end

    // Asynchronous read lanes
    for (genvar g = 0; g < LANES; g++) begin : g_rd
        assign h_rdata_o[g] = mem_q[h_addr_i[g]];
    end
    assign c_rdata_o = mem_q[c_addr_i];
endmodule

// File: rtl/sdbuf_host_port.sv
// Host data-port side.
// Keeps the host byte counter, packs and unpacks little-endian lanes,
// masks the lanes past the end of the block, and reports when a port
// access completes a block. It assumes len_i is stable while a flag is
// set and that len_i never exceeds the buffer depth.
module sdbuf_host_port
    import sdbuf_pkg::*;
#(
    parameter int LEN_W = 12,
    parameter int LANES = 4,
    parameter int AW    = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LEN_W-1:0]         len_i,
    input  logic                     data_avail_i,
    input  logic                     space_avail_i,
    input  logic                     port_rd_i,
    input  logic                     port_wr_i,
    input  logic [1:0]               port_size_i,
    input  logic [LANES*8-1:0]       port_wdata_i,
    input  logic [LANES-1:0][7:0]    mem_rdata_i,
    output logic [LANES-1:0][AW-1:0] mem_addr_o,
    output logic [LANES-1:0]         mem_we_o,
    output logic [LANES-1:0][7:0]    mem_wdata_o,
    output logic [LANES*8-1:0]       port_rdata_o,
    output logic                     rd_done_o,
    output logic                     wr_done_o
);
    localparam int CW = LEN_W + 1;

    logic [LEN_W-1:0]      cnt_q;
    logic [CW-1:0]         remain, nbytes, take, next_cnt;
    logic                  last, rd_acc, wr_acc;
    logic [LANES-1:0]      lane_ok;
    logic [LANES*8-1:0]    rd_pack;

    // Bytes this access moves, clipped to what is left in the block
    always_comb begin
        remain   = {1'b0, len_i} - {1'b0, cnt_q};
        nbytes   = CW'(size_bytes(port_size_i));
        if (nbytes > CW'(LANES)) nbytes = CW'(LANES);
        take     = (nbytes > remain) ? remain : nbytes;
        next_cnt = {1'b0, cnt_q} + take;
        last     = next_cnt >= {1'b0, len_i};
        rd_acc   = port_rd_i && data_avail_i;
        wr_acc   = port_wr_i && space_avail_i && !rd_acc;
    end

    // Per-lane address, write enable and masked read byte
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_ok[g]       = CW'(g) < take;
        assign mem_addr_o[g]    = AW'(cnt_q + LEN_W'(g));
        assign mem_we_o[g]      = wr_acc && lane_ok[g];
        assign mem_wdata_o[g]   = port_wdata_i[8*g +: 8];
        assign rd_pack[8*g +: 8] = lane_ok[g] ? mem_rdata_i[g] : 8'h00;
    end

    assign rd_done_o = rd_acc && last;
    assign wr_done_o = wr_acc && last;

    // Counter advance and registered read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q        <= '0;
            port_rdata_o <= '0;
        end else begin
            if (rd_acc) begin
                port_rdata_o <= rd_pack;
            end else if (port_rd_i) begin
                port_rdata_o <= '0;
            end
            if (rd_acc || wr_acc) begin
                cnt_q <= last ? '0 : next_cnt[LEN_W-1:0];
            end
        end
    end

    AST_RD_IGNORED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (port_rd_i && !data_avail_i) |=> (port_rdata_o == '0)); // R8
    AST_CNT_INSIDE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (data_avail_i || space_avail_i) |-> (cnt_q < len_i)); // R4
    AST_CNT_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done_o || wr_done_o) |=> (cnt_q == '0)); // R4
    AST_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr_i && !space_avail_i) |-> (mem_we_o == '0)); // R8
endmodule

// File: rtl/sdbuf_card_side.sv
// Card side and phase control.
// Runs the fill and drain byte streams over valid/ready, owns the
// transfer phase from which both status flags come, applies the skip
// rule and runs the tuning discard. It assumes len_i is nonzero and
// stable from the start request until the block completes.
module sdbuf_card_side
    import sdbuf_pkg::*;
#(
    parameter int LEN_W = 12,
    parameter int AW    = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] len_i,
    input  logic             multi_blk_i,
    input  logic             blk_cnt_en_i,
    input  logic             blk_cnt_zero_i,
    input  logic             rd_start_i,
    input  logic             wr_start_i,
    input  logic             tune_start_i,
    input  logic             rd_done_i,
    input  logic             wr_done_i,
    input  logic             card_rx_valid_i,
    input  logic [7:0]       card_rx_data_i,
    output logic             card_rx_ready_o,
    output logic             card_tx_valid_o,
    output logic [7:0]       card_tx_data_o,
    input  logic             card_tx_ready_i,
    input  logic [7:0]       mem_rdata_i,
    output logic             mem_we_o,
    output logic [AW-1:0]    mem_addr_o,
    output logic [7:0]       mem_wdata_o,
    output logic             data_avail_o,
    output logic             space_avail_o,
    output logic             exec_tune_o,
    output logic             samp_clk_sel_o,
    output logic             tune_done_o
);
    phase_t           phase_q;
    logic [LEN_W-1:0] ccnt_q;
    logic             c_last, skip, len_ok, rx_beat, tx_beat;

    // Beat and end-of-block decode
    always_comb begin
        c_last  = ({1'b0, ccnt_q} + 1'b1) >= {1'b0, len_i};
        skip    = multi_blk_i && blk_cnt_en_i && blk_cnt_zero_i;
        len_ok  = len_i != '0;
        rx_beat = (phase_q == PH_FILL) && card_rx_valid_i;
        tx_beat = (phase_q == PH_DRAIN) && card_tx_ready_i;
    end

    // Phase sequencing, card byte counter and tuning bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q        <= PH_IDLE;
            ccnt_q         <= '0;
            exec_tune_o    <= 1'b0;
            samp_clk_sel_o <= 1'b0;
            tune_done_o    <= 1'b0;
        end else begin
            tune_done_o <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    ccnt_q <= '0;
                    if (rd_start_i && len_ok && !skip) begin
                        phase_q <= PH_FILL;
                    end else if (wr_start_i && len_ok) begin
                        phase_q <= PH_HOST_WR;
                    end else if (tune_start_i) begin
                        exec_tune_o <= 1'b1;
                    end
                end
                PH_FILL: begin
                    if (rx_beat) begin
                        if (c_last) begin
                            ccnt_q <= '0;
                            if (exec_tune_o) begin
                                exec_tune_o    <= 1'b0;
                                samp_clk_sel_o <= 1'b1;
                                tune_done_o    <= 1'b1;
                                phase_q        <= PH_IDLE;
                            end else begin
                                phase_q <= PH_HOST_RD;
                            end
                        end else begin
                            ccnt_q <= ccnt_q + 1'b1;
                        end
                    end
                end
                PH_HOST_RD: if (rd_done_i) phase_q <= PH_IDLE;
                PH_HOST_WR: if (wr_done_i) phase_q <= PH_DRAIN;
                PH_DRAIN: begin
                    if (tx_beat) begin
                        if (c_last) begin
                            ccnt_q  <= '0;
                            phase_q <= PH_IDLE;
                        end else begin
                            ccnt_q <= ccnt_q + 1'b1;
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign card_rx_ready_o = phase_q == PH_FILL;
    assign card_tx_valid_o = phase_q == PH_DRAIN;
    assign card_tx_data_o  = mem_rdata_i;
    assign mem_addr_o      = AW'(ccnt_q);
    assign mem_wdata_o     = card_rx_data_i;
    assign mem_we_o        = rx_beat && !exec_tune_o;
    assign data_avail_o    = phase_q == PH_HOST_RD;
    assign space_avail_o   = phase_q == PH_HOST_WR;

    AST_SKIP_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE && rd_start_i && skip) |=> !card_rx_ready_o); // R6
    AST_TUNE_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(exec_tune_o) |-> (samp_clk_sel_o && tune_done_o && !data_avail_o)); // R7
    AST_TUNE_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        exec_tune_o |-> !mem_we_o); // R7
    AST_FILL_WAITS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (card_rx_ready_o && !card_rx_valid_i) |=> $stable(ccnt_q)); // R10
    AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (card_tx_valid_o && !card_tx_ready_i) |=> (card_tx_valid_o && $stable(card_tx_data_o))); // R10
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (data_avail_o && !rd_done_i) |=> data_avail_o); // R11
endmodule

// File: rtl/sdbuf_port.sv
// Top of the block buffer data port.
// Joins the host port, the card side and the byte buffer. Buffer depth
// comes from CAP_SEL as 512 << CAP_SEL, and the block length is clamped
// to that depth. CAP_SEL = 3 is rejected at elaboration.
module sdbuf_port
    import sdbuf_pkg::*;
#(
    parameter int CAP_SEL = 0,
    parameter int LEN_W   = 12,
    parameter int LANES   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LEN_W-1:0]   blk_len_i,
    input  logic               multi_blk_i,
    input  logic               blk_cnt_en_i,
    input  logic               blk_cnt_zero_i,
    input  logic               rd_start_i,
    input  logic               wr_start_i,
    input  logic               tune_start_i,
    input  logic               port_rd_i,
    input  logic               port_wr_i,
    input  logic [1:0]         port_size_i,
    input  logic [LANES*8-1:0] port_wdata_i,
    output logic [LANES*8-1:0] port_rdata_o,
    output logic               data_avail_o,
    output logic               space_avail_o,
    input  logic               card_rx_valid_i,
    input  logic [7:0]         card_rx_data_i,
    output logic               card_rx_ready_o,
    output logic               card_tx_valid_o,
    output logic [7:0]         card_tx_data_o,
    input  logic               card_tx_ready_i,
    output logic               exec_tune_o,
    output logic               samp_clk_sel_o,
    output logic               tune_done_o
);
    localparam int DEPTH = 512 << CAP_SEL;
    localparam int AW    = $clog2(DEPTH);

    if (CAP_SEL > 2 || CAP_SEL < 0) begin : g_bad_cap
        initial $fatal(1, "capacity select must be 0, 1 or 2");
    end

    logic [LEN_W-1:0]         len_eff;
    logic [LANES-1:0]         h_we;
    logic [LANES-1:0][AW-1:0] h_addr;
    logic [LANES-1:0][7:0]    h_wdata, h_rdata;
    logic                     c_we;
    logic [AW-1:0]            c_addr;
    logic [7:0]               c_wdata, c_rdata;
    logic                     rd_done, wr_done;

    // Clamp the requested block length to the buffer capacity
    always_comb begin
        if (32'(blk_len_i) > DEPTH) len_eff = LEN_W'(DEPTH);
        else                        len_eff = blk_len_i;
    end

    sdbuf_mem #(.DEPTH(DEPTH), .AW(AW), .LANES(LANES)) u_mem (
        .clk       (clk),
        .h_we_i    (h_we),
        .h_addr_i  (h_addr),
        .h_wdata_i (h_wdata),
        .h_rdata_o (h_rdata),
        .c_we_i    (c_we),
        .c_addr_i  (c_addr),
        .c_wdata_i (c_wdata),
        .c_rdata_o (c_rdata)
    );

    sdbuf_host_port #(.LEN_W(LEN_W), .LANES(LANES), .AW(AW)) u_host (
        .clk           (clk),
        .rst_n         (rst_n),
        .len_i         (len_eff),
        .data_avail_i  (data_avail_o),
        .space_avail_i (space_avail_o),
        .port_rd_i     (port_rd_i),
        .port_wr_i     (port_wr_i),
        .port_size_i   (port_size_i),
        .port_wdata_i  (port_wdata_i),
        .mem_rdata_i   (h_rdata),
        .mem_addr_o    (h_addr),
        .mem_we_o      (h_we),
        .mem_wdata_o   (h_wdata),
        .port_rdata_o  (port_rdata_o),
        .rd_done_o     (rd_done),
        .wr_done_o     (wr_done)
    );

    sdbuf_card_side #(.LEN_W(LEN_W), .AW(AW)) u_card (
        .clk             (clk),
        .rst_n           (rst_n),
        .len_i           (len_eff),
        .multi_blk_i     (multi_blk_i),
        .blk_cnt_en_i    (blk_cnt_en_i),
        .blk_cnt_zero_i  (blk_cnt_zero_i),
        .rd_start_i      (rd_start_i),
        .wr_start_i      (wr_start_i),
        .tune_start_i    (tune_start_i),
        .rd_done_i       (rd_done),
        .wr_done_i       (wr_done),
        .card_rx_valid_i (card_rx_valid_i),
        .card_rx_data_i  (card_rx_data_i),
        .card_rx_ready_o (card_rx_ready_o),
        .card_tx_valid_o (card_tx_valid_o),
        .card_tx_data_o  (card_tx_data_o),
        .card_tx_ready_i (card_tx_ready_i),
        .mem_rdata_i     (c_rdata),
        .mem_we_o        (c_we),
        .mem_addr_o      (c_addr),
        .mem_wdata_o     (c_wdata),
        .data_avail_o    (data_avail_o),
        .space_avail_o   (space_avail_o),
        .exec_tune_o     (exec_tune_o),
        .samp_clk_sel_o  (samp_clk_sel_o),
        .tune_done_o     (tune_done_o)
    );

    AST_FLAGS_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_avail_o && space_avail_o)); // R11
    AST_LEN_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
        (data_avail_o || space_avail_o) |-> (32'(len_eff) <= DEPTH)); // R1
endmodule

// File: tb/sdbuf_port_test.sv
module sdbuf_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] blk_len = 12'd4;
    logic        multi = 1'b0, cnt_en = 1'b0, cnt_zero = 1'b0;
    logic        rd_start = 1'b0, wr_start = 1'b0, tune_start = 1'b0;
    logic        port_rd = 1'b0, port_wr = 1'b0;
    logic [1:0]  port_size = 2'd0;
    logic [31:0] port_wdata = '0;
    logic [31:0] port_rdata;
    logic        data_avail, space_avail;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready, tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic        exec_tune, samp_sel, tune_done;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    sdbuf_port uut (
        .clk(clk), .rst_n(rst_n), .blk_len_i(blk_len), .multi_blk_i(multi),
        .blk_cnt_en_i(cnt_en), .blk_cnt_zero_i(cnt_zero), .rd_start_i(rd_start),
        .wr_start_i(wr_start), .tune_start_i(tune_start), .port_rd_i(port_rd),
        .port_wr_i(port_wr), .port_size_i(port_size), .port_wdata_i(port_wdata),
        .port_rdata_o(port_rdata), .data_avail_o(data_avail), .space_avail_o(space_avail),
        .card_rx_valid_i(rx_valid), .card_rx_data_i(rx_data), .card_rx_ready_o(rx_ready),
        .card_tx_valid_o(tx_valid), .card_tx_data_o(tx_data), .card_tx_ready_i(tx_ready),
        .exec_tune_o(exec_tune), .samp_clk_sel_o(samp_sel), .tune_done_o(tune_done)
    );

    typedef struct packed {
        logic [11:0] len;
        logic [1:0]  size;
        logic [7:0]  seed;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{len: 12'd8,  size: 2'd2, seed: 8'h00},
        '{len: 12'd7,  size: 2'd2, seed: 8'h30},
        '{len: 12'd6,  size: 2'd1, seed: 8'hA0},
        '{len: 12'd5,  size: 2'd0, seed: 8'h5C},
        '{len: 12'd3,  size: 2'd3, seed: 8'hF0},
        '{len: 12'd11, size: 2'd1, seed: 8'h7E}
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // All tasks start and finish just after a falling edge
    task automatic card_fill(input int n, input logic [7:0] seed, input bit gap);
        rd_start = 1'b1;
        @(negedge clk);
        rd_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            rx_valid = 1'b1;
            rx_data  = 8'(seed + i);
            @(negedge clk);
            if (gap && i == 0) begin
                rx_valid = 1'b0;
                rx_data  = 8'hEE;
                @(negedge clk);
            end
        end
        rx_valid = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] sz, output logic [31:0] d);
        port_rd   = 1'b1;
        port_size = sz;
        @(negedge clk);
        port_rd = 1'b0;
        d = port_rdata;
    endtask

    task automatic host_write(input logic [1:0] sz, input logic [31:0] d);
        port_wr    = 1'b1;
        port_size  = sz;
        port_wdata = d;
        @(negedge clk);
        port_wr = 1'b0;
    endtask

    task automatic drain_expect(input logic [7:0] exp_b, input string req);
        check({31'd0, tx_valid}, 32'd1, req);
        check({24'd0, tx_data}, {24'd0, exp_b}, req);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d, exp;
        int nb;
        repeat (3) @(negedge clk);
        // R9: reset state
        check({31'd0, data_avail}, 32'd0, "R9 data_avail");
        check({31'd0, space_avail}, 32'd0, "R9 space_avail");
        check(port_rdata, 32'd0, "R9 rdata");
        check({30'd0, rx_ready, tx_valid}, 32'd0, "R9 card handshake");
        check({30'd0, exec_tune, samp_sel}, 32'd0, "R9 tuning bits");
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R4 R10: table of fills drained by port reads
        foreach (VECS[v]) begin
            blk_len = VECS[v].len;
            card_fill(int'(VECS[v].len), VECS[v].seed, v == 2);
            check({31'd0, data_avail}, 32'd1, "R10 fill raises data_avail");
            nb = (VECS[v].size == 2'd0) ? 1 : (VECS[v].size == 2'd1) ? 2 : 4;
            for (int c = 0; c < int'(VECS[v].len); c += nb) begin
                host_read(VECS[v].size, d);
                exp = '0;
                for (int j = 0; j < nb; j++)
                    if (c + j < int'(VECS[v].len)) exp[8*j +: 8] = 8'(VECS[v].seed + c + j);
                check(d, exp, "R3 packed read");
            end
            check({31'd0, data_avail}, 32'd0, "R4 data_avail clears at block end");
        end

        // R8: read with no data returns zero after a nonzero read
        blk_len = 12'd4;
        card_fill(4, 8'h10, 1'b0);
        host_read(2'd1, d);
        check(d, 32'h0000_1110, "R3 first half");
        // R11: write request while data is pending is ignored
        wr_start = 1'b1;
        @(negedge clk);
        wr_start = 1'b0;
        check({31'd0, space_avail}, 32'd0, "R11 start ignored when busy");
        host_read(2'd1, d);
        check(d, 32'h0000_1312, "R3 second half");
        host_read(2'd2, d);
        check(d, 32'd0, "R8 read ignored when empty");

        // R8 R5: dropped write, then write path with tail lanes dropped
        host_write(2'd2, 32'hDEAD_BEEF);
        blk_len = 12'd6;
        wr_start = 1'b1;
        @(negedge clk);
        wr_start = 1'b0;
        check({31'd0, space_avail}, 32'd1, "R5 space_avail set");
        host_write(2'd2, 32'h4433_2211);
        host_write(2'd2, 32'h8877_6655);
        check({31'd0, space_avail}, 32'd0, "R5 space_avail clears");
        // R10: drain stalled for a cycle holds the byte
        check({24'd0, tx_data}, 32'h11, "R10 held byte");
        @(negedge clk);
        check({24'd0, tx_data}, 32'h11, "R10 held byte stable");
        for (int i = 0; i < 6; i++) drain_expect(8'(8'h11 * (i + 1)), "R5 drain order");
        check({31'd0, tx_valid}, 32'd0, "R5 drain ends");

        // R5: mixed sizes
        blk_len = 12'd3;
        wr_start = 1'b1;
        @(negedge clk);
        wr_start = 1'b0;
        host_write(2'd0, 32'h0000_00A5);
        host_write(2'd1, 32'h0000_C3B4);
        drain_expect(8'hA5, "R5 mixed byte0");
        drain_expect(8'hB4, "R5 mixed byte1");
        drain_expect(8'hC3, "R5 mixed byte2");

        // R2: zero length request ignored
        blk_len = 12'd0;
        rd_start = 1'b1;
        @(negedge clk);
        rd_start = 1'b0;
        check({31'd0, rx_ready}, 32'd0, "R2 zero length ignored");

        // R6: skip condition
        blk_len = 12'd2;
        multi = 1'b1; cnt_en = 1'b1; cnt_zero = 1'b1;
        rd_start = 1'b1;
        @(negedge clk);
        rd_start = 1'b0;
        check({30'd0, rx_ready, data_avail}, 32'd0, "R6 fill skipped");
        cnt_zero = 1'b0;
        card_fill(2, 8'h66, 1'b0);
        check({31'd0, data_avail}, 32'd1, "R6 fill runs when count nonzero");
        host_read(2'd1, d);
        check(d, 32'h0000_6766, "R6 data after fill");
        multi = 1'b0; cnt_en = 1'b0;

        // R7: tuning discards the block
        blk_len = 12'd4;
        tune_start = 1'b1;
        @(negedge clk);
        tune_start = 1'b0;
        check({31'd0, exec_tune}, 32'd1, "R7 tuning bit set");
        card_fill(4, 8'h90, 1'b0);
        check({31'd0, data_avail}, 32'd0, "R7 no data_avail");
        check({30'd0, exec_tune, samp_sel}, 32'd1, "R7 tune clear, samp set");
        check({31'd0, tune_done}, 32'd1, "R7 done pulse");
        @(negedge clk);
        check({31'd0, tune_done}, 32'd0, "R7 done pulse ends");
        host_read(2'd2, d);
        check(d, 32'd0, "R7 discarded block not readable");

        // R1: length above capacity clamps to 512
        blk_len = 12'd600;
        card_fill(512, 8'h00, 1'b0);
        host_read(2'd2, d);
        check(d, 32'h0302_0100, "R1 first word");
        for (int k = 1; k < 127; k++) host_read(2'd2, d);
        check({31'd0, data_avail}, 32'd1, "R1 still pending before last word");
        host_read(2'd2, d);
        check(d, 32'hFFFE_FDFC, "R1 last word");
        check({31'd0, data_avail}, 32'd0, "R1 clears at capacity");

        // R9 R4: reset mid-block restarts counters
        blk_len = 12'd4;
        card_fill(4, 8'h20, 1'b0);
        host_read(2'd0, d);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check({31'd0, data_avail}, 32'd0, "R9 reset clears flag");
        check({31'd0, samp_sel}, 32'd0, "R9 reset clears samp");
        card_fill(4, 8'h40, 1'b0);
        host_read(2'd0, d);
        check(d, 32'h0000_0040, "R4 counter restarts at 0");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule